// File: doc/BRIEF.md
# USB Endpoint FIFO Bus Bridge

This block sits between an APB bus and the receive and transmit endpoint FIFOs of a USB device controller. A processor or DMA controller reads received bytes and writes bytes to send through a single data register. Each access in the APB access phase becomes a one-cycle FIFO strobe. The strobe is issued only when the FIFO can accept it, so bus traffic never causes a FIFO error.

DMA service requests come from the FIFO flags. A receive request is raised while the receive FIFO is full. A transmit request is raised while software has armed transmission and the transmit FIFO has room. When the USB side reports an OUT token, the block sets a pending flag and can raise an interrupt, so software can program the transmit DMA channel and then set the enable bit.

A receive overrun or transmit underrun reported by the FIFOs is latched. While either error is held, all strobes and both DMA requests are suppressed until software clears it. A read-only window returns the 18-byte device descriptor, one byte per 32-bit word.

Top module: `usb_ep_apb_bridge`

## Requirements
- R1: After synchronous reset the control register reads 0, status bits 4 to 6 read 0, and irq, rx_rd, tx_wr, tx_dma_req and rx_dma_req (with rx_full low) are 0.
- R2: An APB write to offset 0x08 pulses tx_wr for exactly the access-phase cycle, with tx_wdata equal to pwdata[7:0], when tx_full is 0 and no error is latched. No pulse occurs when tx_full is 1.
- R3: An APB read of offset 0x08 pulses rx_rd for exactly the access-phase cycle when rx_empty is 0 and no error is latched. prdata is rx_rdata zero-extended. No pulse occurs when rx_empty is 1.
- R4: rx_dma_req equals rx_full while no error is latched.
- R5: tx_dma_req is 1 while control bit 0 (transmit enable) is 1, tx_full is 0 and no error is latched. It falls when tx_full rises.
- R6: A one-cycle pulse on rx_overrun sets status bit 4, and one on tx_underrun sets status bit 5, from the next cycle. While either bit is set, rx_rd, tx_wr, rx_dma_req and tx_dma_req stay 0.
- R7: Writing 1 to status bit 4 or 5 clears that error. Writing 0 leaves it set. After clearing, strobes and DMA requests work again.
- R8: A pulse on out_token sets status bit 6, which stays set until a 1 is written to it. A new token in the same cycle as the clear wins. irq equals status bit 6 AND control bit 1 (interrupt enable).
- R9: Status bits 0 to 3 read rx_full, rx_empty, tx_full and tx_empty.
- R10: Reads of offsets 0x80 + 4*i return descriptor byte i for i = 0 to 17, and 0 for i = 18 to 31. The bytes are 18, 1, 0x00, 0x02, 0, 0, 0, 64, VID low, VID high, PID low, PID high, BCD low, BCD high, 1, 2, 3, 1.
- R11: The control register reads back bits [1:0] with the upper bits 0. Unmapped offsets read 0 and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| rx_full | input | 1 | Receive FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_rdata | input | 8 | Receive FIFO head byte |
| rx_overrun | input | 1 | Receive overrun pulse |
| rx_rd | output | 1 | Receive FIFO pop strobe |
| tx_full | input | 1 | Transmit FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_underrun | input | 1 | Transmit underrun pulse |
| tx_wr | output | 1 | Transmit FIFO push strobe |
| tx_wdata | output | 8 | Transmit FIFO push data |
| out_token | input | 1 | OUT token seen pulse |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| irq | output | 1 | Processor interrupt |

## Verification
On every cycle the assertions check three things. A strobe never targets a FIFO that cannot take it, and the two strobes never coincide. The transmit request is never high against a full FIFO. Error and token flags latch on their input pulse and hold until cleared. The bench scenarios are needed for the rest: the exact byte values of the descriptor window, the register readback layout, write-one-to-clear behaviour, recovery after an error is cleared, and the masking of the interrupt by its enable bit.

// File: rtl/usb_bridge_pkg.sv
package usb_bridge_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int DESC_LEN  = 18;
    localparam int ROM_WORDS = 32;
    localparam int ROM_IDX_W = $clog2(ROM_WORDS);

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DATA = 8'h08;

    // Status bit positions (software visible)
    localparam int ST_RX_FULL  = 0;
    localparam int ST_RX_EMPTY = 1;
    localparam int ST_TX_FULL  = 2;
    localparam int ST_TX_EMPTY = 3;
    localparam int ST_RX_ERR   = 4;
    localparam int ST_TX_ERR   = 5;
    localparam int ST_TOKEN    = 6;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_CTRL,
        RGN_STAT,
        RGN_DATA,
        RGN_ROM
    } region_e;

    typedef struct packed {
        logic irq_en;
        logic tx_en;
    } ctrl_t;

    typedef struct packed {
        logic rx_err;
        logic tx_err;
        logic token;
    } flags_t;

    function automatic logic [BYTE_W-1:0] desc_byte(
        input logic [ROM_IDX_W-1:0] idx,
        input logic [15:0] vid,
        input logic [15:0] pid,
        input logic [15:0] bcd
    );
        logic [BYTE_W-1:0] b;
        case (idx)
            5'd0:    b = 8'(DESC_LEN);
            5'd1:    b = 8'd1;
            5'd2:    b = 8'h00;
            5'd3:    b = 8'h02;
            5'd7:    b = 8'd64;
            5'd8:    b = vid[7:0];
            5'd9:    b = vid[15:8];
            5'd10:   b = pid[7:0];
            5'd11:   b = pid[15:8];
            5'd12:   b = bcd[7:0];
            5'd13:   b = bcd[15:8];
            5'd14:   b = 8'd1;
            5'd15:   b = 8'd2;
            5'd16:   b = 8'd3;
            5'd17:   b = 8'd1;
            default: b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/ep_decode.sv
module ep_decode
    import usb_bridge_pkg::*;
(
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    output region_e              region,
    output logic                 acc_wr,
    output logic                 acc_rd,
    output logic [ROM_IDX_W-1:0] rom_idx
);
    logic [ADDR_W-1:0] word_addr;

    assign word_addr = {paddr[ADDR_W-1:2], 2'b00};
    assign acc_wr    = psel & penable & pwrite;
    assign acc_rd    = psel & penable & ~pwrite;
    assign rom_idx   = paddr[ROM_IDX_W+1:2];

    always_comb begin
        if (paddr[ADDR_W-1])            region = RGN_ROM;
        else if (word_addr == OFS_CTRL) region = RGN_CTRL;
        else if (word_addr == OFS_STAT) region = RGN_STAT;
        else if (word_addr == OFS_DATA) region = RGN_DATA;
        else                            region = RGN_NONE;
    end
endmodule

// File: rtl/ep_ctrl_status.sv
module ep_ctrl_status
    import usb_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_stat,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_overrun,
    input  logic              tx_underrun,
    input  logic              out_token,
    output ctrl_t             ctrl,
    output flags_t            flags,
    output logic              irq
);
    flags_t clr;

    always_comb begin
        clr.rx_err = wr_stat & wdata[ST_RX_ERR];
        clr.tx_err = wr_stat & wdata[ST_TX_ERR];
        clr.token  = wr_stat & wdata[ST_TOKEN];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            flags <= '0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_t'(wdata[1:0]);
            flags.rx_err <= rx_overrun  | (flags.rx_err & ~clr.rx_err);
            flags.tx_err <= tx_underrun | (flags.tx_err & ~clr.tx_err);
            flags.token  <= out_token   | (flags.token  & ~clr.token);
        end
    end

    assign irq = flags.token & ctrl.irq_en;

    // R6
    rx_err_latch_chk: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |=> flags.rx_err);
    // R7
    rx_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.rx_err && !(wr_stat && wdata[ST_RX_ERR])) |=> flags.rx_err);
    // R8
    token_latch_chk: assert property (@(posedge clk) disable iff (rst)
        out_token |=> flags.token);
endmodule

// File: rtl/ep_fifo_gate.sv
module ep_fifo_gate
    import usb_bridge_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  region_e region,
    input  logic    acc_wr,
    input  logic    acc_rd,
    input  logic    rx_full,
    input  logic    rx_empty,
    input  logic    tx_full,
    input  logic    err_any,
    input  logic    tx_en,
    output logic    rx_rd,
    output logic    tx_wr,
    output logic    rx_dma_req,
    output logic    tx_dma_req
);
    logic hit_data;

    assign hit_data   = (region == RGN_DATA);
    assign rx_rd      = acc_rd & hit_data & ~rx_empty & ~err_any;
    assign tx_wr      = acc_wr & hit_data & ~tx_full  & ~err_any;
    assign rx_dma_req = rx_full & ~err_any;
    assign tx_dma_req = tx_en & ~tx_full & ~err_any;

    // R3
    rd_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
        rx_rd |-> !rx_empty);
    // R2
    wr_not_full_chk: assert property (@(posedge clk) disable iff (rst)
        tx_wr |-> !tx_full);
    // R2
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_rd, tx_wr}));
    // R5
    tx_req_room_chk: assert property (@(posedge clk) disable iff (rst)
        tx_dma_req |-> !tx_full);
endmodule

// File: rtl/usb_ep_apb_bridge.sv
module usb_ep_apb_bridge
    import usb_bridge_pkg::*;
#(
    parameter logic [15:0] VID = 16'h1A2B,
    parameter logic [15:0] PID = 16'h3C4D,
    parameter logic [15:0] BCD = 16'h0105
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              rx_full,
    input  logic              rx_empty,
    input  logic [BYTE_W-1:0] rx_rdata,
    input  logic              rx_overrun,
    output logic              rx_rd,
    input  logic              tx_full,
    input  logic              tx_empty,
    input  logic              tx_underrun,
    output logic              tx_wr,
    output logic [BYTE_W-1:0] tx_wdata,
    input  logic              out_token,
    output logic              rx_dma_req,
    output logic              tx_dma_req,
    output logic              irq
);
    region_e              region;
    logic                 acc_wr, acc_rd;
    logic [ROM_IDX_W-1:0] rom_idx;
    ctrl_t                ctrl;
    flags_t               flags;
    logic                 err_any;

    ep_decode u_dec (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .region(region), .acc_wr(acc_wr), .acc_rd(acc_rd), .rom_idx(rom_idx)
    );

    ep_ctrl_status u_cs (
        .clk(clk), .rst(rst),
        .wr_ctrl(acc_wr && region == RGN_CTRL),
        .wr_stat(acc_wr && region == RGN_STAT),
        .wdata(pwdata),
        .rx_overrun(rx_overrun), .tx_underrun(tx_underrun), .out_token(out_token),
        .ctrl(ctrl), .flags(flags), .irq(irq)
    );

    assign err_any = flags.rx_err | flags.tx_err;

    ep_fifo_gate u_gate (
        .clk(clk), .rst(rst), .region(region), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .rx_full(rx_full), .rx_empty(rx_empty), .tx_full(tx_full),
        .err_any(err_any), .tx_en(ctrl.tx_en),
        .rx_rd(rx_rd), .tx_wr(tx_wr),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
    );

    assign tx_wdata = pwdata[BYTE_W-1:0];

    always_comb begin
        prdata = '0;
        case (region)
            RGN_CTRL: prdata[1:0] = ctrl;
            RGN_STAT: begin
                prdata[ST_RX_FULL]  = rx_full;
                prdata[ST_RX_EMPTY] = rx_empty;
                prdata[ST_TX_FULL]  = tx_full;
                prdata[ST_TX_EMPTY] = tx_empty;
                prdata[ST_RX_ERR]   = flags.rx_err;
                prdata[ST_TX_ERR]   = flags.tx_err;
                prdata[ST_TOKEN]    = flags.token;
            end
            RGN_DATA: prdata[BYTE_W-1:0] = rx_rdata;
            RGN_ROM:  prdata[BYTE_W-1:0] = desc_byte(rom_idx, VID, PID, BCD);
            default:  prdata = '0;
        endcase
    end

    // R6
    err_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        err_any |-> !(rx_rd || tx_wr || rx_dma_req || tx_dma_req));
    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.irq_en |-> !irq);
endmodule

// File: tb/usb_ep_apb_bridge_tb.sv
module usb_ep_apb_bridge_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [7:0]  paddr = 0;
    logic [31:0] pwdata = 0;
    logic [31:0] prdata;
    logic        rx_full = 0, rx_empty = 1, rx_overrun = 0, rx_rd;
    logic [7:0]  rx_rdata = 8'h5A;
    logic        tx_full = 0, tx_empty = 1, tx_underrun = 0, tx_wr;
    logic [7:0]  tx_wdata;
    logic        out_token = 0, rx_dma_req, tx_dma_req, irq;

    int checks = 0, fails = 0;
    logic        cap_str, cap_post;
    logic [31:0] cap_data;

    always #5 clk = ~clk;

    usb_ep_apb_bridge u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_rdata(rx_rdata),
        .rx_overrun(rx_overrun), .rx_rd(rx_rd),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_underrun(tx_underrun),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .out_token(out_token),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write; captures tx_wr in access phase, and one cycle later
    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1; #1 cap_str = tx_wr; cap_data = {24'd0, tx_wdata};
        @(negedge clk); psel = 0; penable = 0; #1 cap_post = tx_wr;
    endtask

    task automatic apb_rd(input logic [7:0] a);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1; #1 cap_str = rx_rd; cap_data = prdata;
        @(negedge clk); psel = 0; penable = 0; #1 cap_post = rx_rd;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: rx_overrun = 1;
            1: tx_underrun = 1;
            default: out_token = 1;
        endcase
        @(negedge clk); rx_overrun = 0; tx_underrun = 0; out_token = 0;
    endtask

    // vector: {rx_full, tx_full, tx_en, exp_rx_dma, exp_tx_dma}
    localparam logic [4:0] VEC [8] = '{
        5'b00000, 5'b10010, 5'b00101, 5'b01100,
        5'b11110, 5'b10111, 5'b01000, 5'b00000
    };

    function automatic logic [7:0] exp_desc(input int i);
        logic [7:0] t [18] = '{8'd18, 8'd1, 8'h00, 8'h02, 8'd0, 8'd0, 8'd0, 8'd64,
                               8'h2B, 8'h1A, 8'h4D, 8'h3C, 8'h05, 8'h01,
                               8'd1, 8'd2, 8'd3, 8'd1};
        return (i < 18) ? t[i] : 8'd0;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 dma", {30'd0, rx_dma_req, tx_dma_req}, 0);
        chk("R1 strobes", {30'd0, rx_rd, tx_wr}, 0);
        apb_rd(8'h00); chk("R1 ctrl", cap_data, 0);
        apb_rd(8'h04); chk("R1/R9 status", cap_data, 32'h0000000A);

        // R4 R5 table walk
        foreach (VEC[i]) begin
            apb_wr(8'h00, {31'd0, VEC[i][2]});
            @(negedge clk); rx_full = VEC[i][4]; tx_full = VEC[i][3]; #1;
            chk("R4 rx_dma_req", {31'd0, rx_dma_req}, {31'd0, VEC[i][1]});
            chk("R5 tx_dma_req", {31'd0, tx_dma_req}, {31'd0, VEC[i][0]});
        end
        rx_full = 0; tx_full = 0;
        apb_wr(8'h00, 32'hFFFF_FFFF);
        apb_rd(8'h00); chk("R11 ctrl readback", cap_data, 32'h3);
        apb_wr(8'h00, 0);

        // R9 status flags
        @(negedge clk); rx_full = 1; rx_empty = 0; tx_full = 1; tx_empty = 0;
        apb_rd(8'h04); chk("R9 status flags", cap_data, 32'h5);
        rx_full = 0; tx_full = 0; tx_empty = 1;

        // R2 write strobe
        apb_wr(8'h08, 32'hABCD_12C3);
        chk("R2 tx_wr pulse", {31'd0, cap_str}, 1);
        chk("R2 tx_wdata", cap_data, 32'hC3);
        chk("R2 one cycle", {31'd0, cap_post}, 0);
        tx_full = 1;
        apb_wr(8'h08, 32'h11); chk("R2 full no strobe", {31'd0, cap_str}, 0);
        tx_full = 0;

        // R3 read strobe
        rx_rdata = 8'hE7;
        apb_rd(8'h08);
        chk("R3 rx_rd pulse", {31'd0, cap_str}, 1);
        chk("R3 data", cap_data, 32'hE7);
        chk("R3 one cycle", {31'd0, cap_post}, 0);
        rx_empty = 1;
        apb_rd(8'h08); chk("R3 empty no strobe", {31'd0, cap_str}, 0);
        rx_empty = 0;

        // R6 R7 errors
        pulse(0);
        #1;
        apb_rd(8'h04); chk("R6 rx err bit", cap_data & 32'h30, 32'h10);
        @(negedge clk); rx_full = 1; #1;
        chk("R6 rx_dma blocked", {31'd0, rx_dma_req}, 0);
        apb_rd(8'h08); chk("R6 rd blocked", {31'd0, cap_str}, 0);
        apb_wr(8'h08, 32'h22); chk("R6 wr blocked", {31'd0, cap_str}, 0);
        apb_wr(8'h04, 32'h0); apb_rd(8'h04);
        chk("R7 write 0 keeps", cap_data & 32'h10, 32'h10);
        apb_wr(8'h04, 32'h10); apb_rd(8'h04);
        chk("R7 cleared", cap_data & 32'h10, 0);
        #1 chk("R7 rx_dma restored", {31'd0, rx_dma_req}, 1);
        rx_full = 0;
        pulse(1);
        apb_wr(8'h00, 32'h1);
        #1 chk("R6 tx err blocks tx_dma", {31'd0, tx_dma_req}, 0);
        apb_rd(8'h04); chk("R6 tx err bit", cap_data & 32'h30, 32'h20);
        apb_wr(8'h04, 32'h20);
        #1 chk("R7 tx_dma restored", {31'd0, tx_dma_req}, 1);
        apb_wr(8'h08, 32'h33); chk("R7 wr restored", {31'd0, cap_str}, 1);
        apb_wr(8'h00, 32'h0);

        // R8 token / interrupt
        pulse(2);
        #1 chk("R8 masked irq", {31'd0, irq}, 0);
        apb_rd(8'h04); chk("R8 token bit", cap_data & 32'h40, 32'h40);
        apb_wr(8'h00, 32'h2);
        #1 chk("R8 irq on", {31'd0, irq}, 1);
        apb_wr(8'h04, 32'h40);
        #1 chk("R8 irq cleared", {31'd0, irq}, 0);
        // token arrives in the clear cycle: set wins
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 8'h04; pwdata = 32'h40;
        @(negedge clk); penable = 1; out_token = 1;
        @(negedge clk); psel = 0; penable = 0; out_token = 0; #1;
        chk("R8 set wins", {31'd0, irq}, 1);
        apb_wr(8'h04, 32'h40); apb_wr(8'h00, 0);

        // R10 descriptor window
        for (int i = 0; i < 32; i += 3) begin
            apb_rd(8'h80 + 8'(4 * i));
            chk("R10 desc byte", cap_data, {24'd0, exp_desc(i)});
        end
        apb_rd(8'hC4); chk("R10 last byte", cap_data, 32'd1);

        // R11 unmapped
        apb_wr(8'h20, 32'hFFFF_FFFF);
        apb_rd(8'h20); chk("R11 unmapped read", cap_data, 0);
        apb_rd(8'h00); chk("R11 unmapped write no effect", cap_data, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule